// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns the low column address bits of a burst command into the column offset of each beat. A start strobe captures the start offset and three selects: sequential or interleaved ordering, a four-beat chopped burst or a full eight-beat burst, and read or write. The block then presents one beat at a time. It advances by one beat on each cycle in which the beat enable is high. Every burst spans eight beat slots, even a chopped one.

Reads honour any start offset. Writes are forced onto an aligned boundary. A full-length write always runs in ascending order from offset zero. A chopped write keeps only the top address bit, which selects the lower or upper nibble. In a chopped burst the last four slots carry no data, and the valid flag is low for those slots so the data pins can be left undriven.

The block is meant to sit between a memory controller's command scheduler and its data-path sequencer. The sequencer uses the offset to select a word from a burst buffer, and uses the valid flag to enable its output drivers.

Top module: `burst_col_order`

## Requirements
- R1: After reset, `beat_vld_o` is 0, `done_o` is 0 and `beat_ofs_o` is 0.
- R2: For a read with `chop_i`=0 and `ilv_i`=0 (sequential), beat k (k=0..7) of start offset s has offset {s[2] XOR k[2], (s[1:0]+k[1:0]) mod 4}. For example, start 1 gives 1,2,3,0,5,6,7,4.
- R3: For a read with `chop_i`=0 and `ilv_i`=1 (interleaved), beat k has offset k XOR s. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R4: For a read with `chop_i`=1, beats 0..3 follow the R2 or R3 formula and so stay in the nibble chosen by s[2]. Beats 4..7 have `beat_vld_o`=0 and `beat_ofs_o`=0.
- R5: For a write with `chop_i`=1, s[1:0] are ignored: beats 0..3 give 4*s[2]+k under either ordering, and beats 4..7 are marked not driven as in R4.
- R6: For a write with `chop_i`=0, beat k has offset k, whatever the start offset and ordering.
- R7: The beat index advances by one on each cycle in which `beat_en_i`=1. While `beat_en_i`=0 the offset and the valid flag hold their values.
- R8: `done_o` is high only in the cycle where `beat_en_i`=1 on the eighth beat. In the next cycle the block is idle and `beat_vld_o`=0.
- R9: A `start_i` pulse that arrives while a burst is active is ignored, including a pulse in the `done_o` cycle. The running burst keeps its offsets, and no new burst follows.
- R10: A `start_i` pulse sampled at a clock edge while idle presents beat 0 in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst launch strobe |
| col_lo_i | input | OFS_W | Start column offset (low address bits) |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| chop_i | input | 1 | 1 = four-beat chop, 0 = eight-beat burst |
| wr_i | input | 1 | 1 = write, 0 = read |
| beat_en_i | input | 1 | Advance to next beat |
| beat_ofs_o | output | OFS_W | Column offset of the current beat |
| beat_vld_o | output | 1 | Current beat carries data (0 = undriven) |
| done_o | output | 1 | Final beat accepted |

## Verification
On every cycle, the assertions check several properties. Beat indices step correctly, offsets hold while beats are stalled, and a chopped burst never leaves its nibble. A full write tracks the beat index exactly, a late start strobe never disturbs the captured configuration, and the block goes idle after done. The exact offset sequences for each start value, ordering, length and direction can only be shown by the bench's sweep over all 64 combinations. The same holds for the zeroed undriven slots and the one-cycle launch latency.

// File: rtl/bco_pkg.sv
package bco_pkg;
   typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} ord_e;
   typedef enum logic {LEN_FULL = 1'b0, LEN_CHOP = 1'b1} len_e;
   typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;
endpackage

// File: rtl/bco_beat_ctr.sv
module bco_beat_ctr #(
   parameter int BEATS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       launch_i,
   input  logic                       adv_i,
   output logic                       active_o,
   output logic [$clog2(BEATS)-1:0]   cnt_o,
   output logic                       last_o
);
   localparam int CW = $clog2(BEATS);

   logic          active_q;
   logic [CW-1:0] cnt_q;

   assign last_o   = active_q & adv_i & (cnt_q == CW'(BEATS - 1));
   assign active_o = active_q;
   assign cnt_o    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!active_q) begin
         if (launch_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
         end
      end else if (adv_i) begin
         if (last_o) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   // R7: each accepted beat moves the index by exactly one
   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && adv_i && !last_o) |=> (cnt_q == $past(cnt_q) + CW'(1)));

   // R10: a launch from idle always starts at beat zero
   p_launch_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && launch_i) |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/bco_start_norm.sv
module bco_start_norm #(
   parameter int OFS_W = 3
) (
   input  logic [OFS_W-1:0] raw_i,
   input  bco_pkg::len_e    len_i,
   input  bco_pkg::dir_e    dir_i,
   output logic [OFS_W-1:0] eff_o
);
   import bco_pkg::*;

   always_comb begin
      eff_o = raw_i;
      if (dir_i == DIR_WR) begin
         if (len_i == LEN_CHOP) eff_o = {raw_i[OFS_W-1], {(OFS_W-1){1'b0}}};
         else                   eff_o = '0;
      end
   end
endmodule

// File: rtl/bco_order_map.sv
module bco_order_map #(
   parameter int OFS_W = 3
) (
   input  logic [OFS_W-1:0] start_i,
   input  logic [OFS_W-1:0] cnt_i,
   input  logic             active_i,
   input  bco_pkg::ord_e    ord_i,
   input  bco_pkg::len_e    len_i,
   output logic [OFS_W-1:0] ofs_o,
   output logic             drive_o
);
   import bco_pkg::*;

   localparam int HW = OFS_W - 1;

   logic [OFS_W-1:0] ilv_ofs;
   logic [OFS_W-1:0] seq_ofs;

   for (genvar b = 0; b < OFS_W; b++) begin : g_xor
      assign ilv_ofs[b] = start_i[b] ^ cnt_i[b];
   end

   assign seq_ofs = {start_i[OFS_W-1] ^ cnt_i[OFS_W-1], start_i[HW-1:0] + cnt_i[HW-1:0]};

   assign drive_o = active_i & ((len_i == LEN_FULL) | ~cnt_i[OFS_W-1]);
   assign ofs_o   = drive_o ? ((ord_i == ORD_ILV) ? ilv_ofs : seq_ofs) : '0;
endmodule

// File: rtl/burst_col_order.sv
module burst_col_order #(
   parameter int OFS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [OFS_W-1:0] col_lo_i,
   input  logic             ilv_i,
   input  logic             chop_i,
   input  logic             wr_i,
   input  logic             beat_en_i,
   output logic [OFS_W-1:0] beat_ofs_o,
   output logic             beat_vld_o,
   output logic             done_o
);
   import bco_pkg::*;

   localparam int BEATS = 1 << OFS_W;
   localparam int MSB   = OFS_W - 1;

   if (OFS_W < 2) begin : g_bad_width
      $error("burst_col_order: OFS_W must be at least 2");
   end

   logic             active;
   logic [OFS_W-1:0] cnt;
   logic             launch;
   logic [OFS_W-1:0] norm_start;

   logic [OFS_W-1:0] cfg_start_q;
   ord_e             cfg_ord_q;
   len_e             cfg_len_q;
   dir_e             cfg_dir_q;

   assign launch = start_i & ~active;

   bco_start_norm #(.OFS_W(OFS_W)) u_norm (
      .raw_i (col_lo_i),
      .len_i (len_e'(chop_i)),
      .dir_i (dir_e'(wr_i)),
      .eff_o (norm_start)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_start_q <= '0;
         cfg_ord_q   <= ORD_SEQ;
         cfg_len_q   <= LEN_FULL;
         cfg_dir_q   <= DIR_RD;
      end else if (launch) begin
         cfg_start_q <= norm_start;
         cfg_ord_q   <= ord_e'(ilv_i);
         cfg_len_q   <= len_e'(chop_i);
         cfg_dir_q   <= dir_e'(wr_i);
      end
   end

   bco_beat_ctr #(.BEATS(BEATS)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .adv_i    (beat_en_i),
      .active_o (active),
      .cnt_o    (cnt),
      .last_o   (done_o)
   );

   bco_order_map #(.OFS_W(OFS_W)) u_map (
      .start_i  (cfg_start_q),
      .cnt_i    (cnt),
      .active_i (active),
      .ord_i    (cfg_ord_q),
      .len_i    (cfg_len_q),
      .ofs_o    (beat_ofs_o),
      .drive_o  (beat_vld_o)
   );

   // R4 / R5: a chopped burst stays inside the nibble of its start
   p_chop_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && cfg_len_q == LEN_CHOP) |-> (beat_ofs_o[MSB] == cfg_start_q[MSB]));

   // R6: a full write follows the beat index
   p_wr_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld_o && cfg_dir_q == DIR_WR && cfg_len_q == LEN_FULL) |-> (beat_ofs_o == cnt));

   // R7: a stalled beat keeps its offset
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !beat_en_i) |=> ($stable(beat_ofs_o) && $stable(beat_vld_o)));

   // R8: after done the block is idle
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !beat_vld_o);

   // R9: a start strobe during a burst leaves the configuration alone
   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && start_i) |=> ($stable(cfg_start_q) && $stable(cfg_ord_q) && $stable(cfg_len_q)));
endmodule

// File: tb/tb_burst_col_order.sv
`timescale 1ns/1ps
module tb_burst_col_order;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       start_i;
   logic [2:0] col_lo_i;
   logic       ilv_i;
   logic       chop_i;
   logic       wr_i;
   logic       beat_en_i;
   logic [2:0] beat_ofs_o;
   logic       beat_vld_o;
   logic       done_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   burst_col_order #(.OFS_W(3)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_lo_i(col_lo_i),
      .ilv_i(ilv_i), .chop_i(chop_i), .wr_i(wr_i), .beat_en_i(beat_en_i),
      .beat_ofs_o(beat_ofs_o), .beat_vld_o(beat_vld_o), .done_o(done_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // returns {valid, offset[2:0]} from the requirement formulas
   function automatic int exp_beat(input int s, input int il, input int ch,
                                   input int wr, input int k);
      int st;
      int o;
      st = s;
      if (wr != 0) st = (ch != 0) ? (s & 4) : 0;
      if (ch != 0 && k >= 4) return 0;
      if (il != 0) o = k ^ st;
      else         o = ((st ^ k) & 4) | (((st & 3) + (k & 3)) & 3);
      return 8 | o;
   endfunction

   function automatic string tag(input int il, input int ch, input int wr);
      if (wr != 0) return (ch != 0) ? "R5" : "R6";
      if (ch != 0) return "R4";
      return (il != 0) ? "R3" : "R2";
   endfunction

   task automatic run_burst(input int s, input int il, input int ch, input int wr,
                            input bit gap, input bit poke);
      int e;
      @(negedge clk);
      start_i = 1'b1; col_lo_i = 3'(s); ilv_i = il[0]; chop_i = ch[0]; wr_i = wr[0];
      beat_en_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < 8; k++) begin
         if (poke && k >= 3) begin
            start_i = 1'b1; col_lo_i = 3'(s + 3); ilv_i = ~il[0]; chop_i = ~ch[0]; wr_i = ~wr[0];
         end
         e = exp_beat(s, il, ch, wr, k);
         if (gap && k == 2) begin
            beat_en_i = 1'b0;
            #1;
            check("R7 stall offset", int'(beat_ofs_o), e & 7);
            check("R7 stall valid", int'(beat_vld_o), e >> 3);
            @(negedge clk);
         end
         beat_en_i = 1'b1;
         #1;
         check(poke ? "R9 offset" : (k == 0 ? "R10 beat0" : tag(il, ch, wr)),
               int'(beat_ofs_o), e & 7);
         check(poke ? "R9 valid" : tag(il, ch, wr), int'(beat_vld_o), e >> 3);
         check("R8 done", int'(done_o), (k == 7) ? 1 : 0);
         @(negedge clk);
      end
      beat_en_i = 1'b0;
      start_i = 1'b0;
      #1;
      check(poke ? "R9 no relaunch" : "R8 idle", int'(beat_vld_o), 0);
      check("R8 done low", int'(done_o), 0);
   endtask

   initial begin
      rst_n = 1'b0; start_i = 1'b0; col_lo_i = '0; ilv_i = 1'b0; chop_i = 1'b0;
      wr_i = 1'b0; beat_en_i = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check("R1 vld", int'(beat_vld_o), 0);
      check("R1 done", int'(done_o), 0);
      check("R1 ofs", int'(beat_ofs_o), 0);
      rst_n = 1'b1;
      for (int wr = 0; wr < 2; wr++)
         for (int ch = 0; ch < 2; ch++)
            for (int il = 0; il < 2; il++)
               for (int s = 0; s < 8; s++)
                  run_burst(s, il, ch, wr, (s % 3) == 1, 1'b0);
      run_burst(5, 1, 0, 0, 1'b0, 1'b1);
      run_burst(6, 0, 1, 0, 1'b1, 1'b1);
      run_burst(3, 0, 0, 1, 1'b0, 1'b1);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule